// File: doc/BRIEF.md
# SPI Ferroelectric-Style Serial Memory Slave

This block is an SPI slave, clock mode 0, that looks to a host like a small non-volatile byte memory. A transaction opens when chip select falls. The first byte is an instruction. Array reads and writes then take a two-byte address, most significant byte first, and stream data for as long as chip select stays low. The address pointer steps once per byte and wraps at the end of the array. There are no pages, and every byte is stored the moment its last bit arrives.

Three mechanisms guard against stray modification. A write-enable latch must be set before any array or status write, and it drops again when such a write closes. Two protect bits in the status register fence off the upper quarter, the upper half or all of the array. An active-low write-protect pin freezes the status register and the enable latch, but only while the status lock-enable bit is set. An active-low hold pin pauses a transfer without ending it.

The block runs on a fast system clock and oversamples the SPI pins through synchronizers. The serial clock must therefore stay well below half the system clock rate. The array depth is set by `AW` (2**AW bytes). Address bits above `AW` are ignored. MISO is returned as a data bit plus an output-enable that a pad wrapper turns into a tri-state pin.

Top module: `spi_fram_slave`

## Requirements
- R1: MOSI is sampled on rising SCK and MISO changes on falling SCK, MSB first. The first byte after chip select falls is the instruction. Codes other than 0x01..0x06 are ignored, with no state change, until chip select rises.
- R2: READ (0x03), two address bytes (high first, only the low AW bits used), then data. The byte at the address is driven from the falling edge that follows the last address bit, and each later byte comes from the next address.
- R3: WRITE (0x02), two address bytes, then data. Each complete byte is stored at the pointer and the pointer steps by one, wrapping from 2**AW-1 to 0. An incomplete byte at chip select rise is discarded.
- R4: WREN (0x06) sets the write-enable latch. WRDI (0x04) clears it.
- R5: A WRITE or WRSR issued while the latch is 0 changes nothing.
- R6: The latch clears when chip select rises after an accepted WRITE or WRSR instruction.
- R7: RDSR (0x05) returns the status byte {lock-enable, 0, 0, 0, BP1, BP0, latch, 0}, repeated for as long as chip select stays low.
- R8: WRSR (0x01) loads bit 7 of its data byte into lock-enable and bits 3:2 into BP1:BP0 when the byte completes.
- R9: BP=00 protects nothing, 01 protects the top quarter, 10 the top half and 11 the whole array. Writes to protected bytes are dropped, and the pointer still advances.
- R10: With lock-enable 1 and the write-protect pin low, WREN and WRSR are ignored. With lock-enable 0 the pin has no effect.
- R11: Hold taken low while SCK is low pauses the transfer. SCK edges are ignored and the MISO enable is low until hold returns high, and the transfer then resumes where it stopped.
- R12: After reset the latch and the status bits are 0. The MISO enable is high only while READ or RDSR data is being shifted out under a low chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| hold_n | input | 1 | Hold pin, active low |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for MISO |

## Verification
A wrong pointer shows up on the first byte of a READ that follows it. It appears on the very first falling SCK edge of the data phase, or one byte after a wrap. A latch or protect bit that holds the wrong value stays invisible until a later write lands or is dropped, so the bench follows each such write with a read-back or an RDSR in the next transaction. A stuck hold or enable state shows at once on the MISO enable, which the bench watches on every clock while chip select is idle and inside each hold window.

// File: rtl/spi_fram_pkg.sv
package spi_fram_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_RD_DATA,
    PH_WR_DATA,
    PH_STAT_OUT,
    PH_STAT_IN,
    PH_DISCARD
  } phase_e;

  // Protect-bit decode on the two top address bits of the array.
  function automatic logic bp_hit(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/fram_pin_sync.sv
module fram_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  input  logic hold_n,
  output logic cs_s,
  output logic mosi_s,
  output logic wp_s,
  output logic rise_e,
  output logic fall_e,
  output logic hold_on
);
  localparam int NPIN = 5;
  // Order: cs_n, sck, mosi, wp_n, hold_n (bit 0 upward).
  localparam logic [NPIN-1:0] RST_VAL = 5'b11001;

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic            sck_p;

  assign pin_raw = {hold_n, wp_n, mosi, sck, cs_n};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {SYNC_STAGES{RST_VAL[g]}};
      else     chain <= {chain[SYNC_STAGES-2:0], pin_raw[g]};
    end
    assign pin_s[g] = chain[SYNC_STAGES-1];
  end

  logic sck_s, hold_s;
  assign cs_s   = pin_s[0];
  assign sck_s  = pin_s[1];
  assign mosi_s = pin_s[2];
  assign wp_s   = pin_s[3];
  assign hold_s = pin_s[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p   <= 1'b0;
      hold_on <= 1'b0;
    end else begin
      sck_p <= sck_s;
      if (cs_s)                               hold_on <= 1'b0;
      else if (!hold_on && !hold_s && !sck_s) hold_on <= 1'b1;
      else if (hold_on && hold_s)             hold_on <= 1'b0;
    end
  end

  assign rise_e = !cs_s && !hold_on && sck_s && !sck_p;
  assign fall_e = !cs_s && !hold_on && !sck_s && sck_p;

endmodule

// File: rtl/fram_array.sv
module fram_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end

endmodule

// File: rtl/fram_ctrl.sv
module fram_ctrl
  import spi_fram_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          mosi_s,
  input  logic          wp_s,
  input  logic          rise_e,
  input  logic          fall_e,
  input  logic          hold_on,
  input  logic [7:0]    ram_q,
  output logic          ram_we,
  output logic [AW-1:0] ptr,
  output logic [7:0]    ram_wdata,
  output logic          miso,
  output logic          miso_oe,
  output logic          wel,
  output logic          wpen,
  output logic [1:0]    bp,
  output logic          st_we,
  output logic          armed
);
  localparam int HIW = AW - 8;

  phase_e          ph;
  logic [2:0]      bit_cnt;
  logic [6:0]      rx_sr;
  logic [7:0]      rx_byte;
  logic [7:0]      op_q;
  logic [HIW-1:0]  addr_hi;
  logic [7:0]      tx_sr;
  logic            tx_active;
  logic            byte_done;
  logic            locked;
  logic            prot;
  logic            out_phase;
  logic [7:0]      stat_byte;
  logic [7:0]      load_byte;

  assign rx_byte   = {rx_sr, mosi_s};
  assign byte_done = rise_e && (bit_cnt == 3'd7);
  assign locked    = wpen && !wp_s;
  assign prot      = bp_hit(bp, ptr[AW-1:AW-2]);
  assign out_phase = (ph == PH_RD_DATA) || (ph == PH_STAT_OUT);
  assign stat_byte = {wpen, 3'b000, bp, wel, 1'b0};
  assign load_byte = (ph == PH_STAT_OUT) ? stat_byte : ram_q;

  assign ram_we    = byte_done && (ph == PH_WR_DATA) && armed && !prot;
  assign ram_wdata = rx_byte;
  assign st_we     = byte_done && (ph == PH_STAT_IN) && armed && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_OPCODE;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      op_q      <= '0;
      addr_hi   <= '0;
      ptr       <= '0;
      tx_sr     <= '0;
      tx_active <= 1'b0;
      armed     <= 1'b0;
      wel       <= 1'b0;
      wpen      <= 1'b0;
      bp        <= 2'b00;
      miso      <= 1'b0;
      miso_oe   <= 1'b0;
    end else if (cs_s) begin
      ph        <= PH_OPCODE;
      bit_cnt   <= '0;
      tx_active <= 1'b0;
      miso_oe   <= 1'b0;
      armed     <= 1'b0;
      if (armed) wel <= 1'b0;
    end else begin
      miso_oe <= tx_active && !hold_on;

      if (rise_e) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sr   <= rx_byte[6:0];
      end

      if (byte_done) begin
        case (ph)
          PH_OPCODE: begin
            op_q <= rx_byte;
            case (rx_byte)
              OP_WREN: begin
                if (!locked) wel <= 1'b1;
                ph <= PH_DISCARD;
              end
              OP_WRDI: begin
                wel <= 1'b0;
                ph  <= PH_DISCARD;
              end
              OP_RDSR:  ph <= PH_STAT_OUT;
              OP_WRSR: begin
                armed <= wel && !locked;
                ph    <= PH_STAT_IN;
              end
              OP_READ:  ph <= PH_ADDR_HI;
              OP_WRITE: begin
                armed <= wel;
                ph    <= PH_ADDR_HI;
              end
              default:  ph <= PH_DISCARD;
            endcase
          end
          PH_ADDR_HI: begin
            addr_hi <= rx_byte[HIW-1:0];
            ph      <= PH_ADDR_LO;
          end
          PH_ADDR_LO: begin
            ptr <= {addr_hi, rx_byte};
            ph  <= (op_q == OP_READ) ? PH_RD_DATA : PH_WR_DATA;
          end
          PH_WR_DATA: ptr <= ptr + 1'b1;
          PH_STAT_IN: begin
            if (st_we) begin
              wpen <= rx_byte[7];
              bp   <= rx_byte[3:2];
            end
            ph <= PH_DISCARD;
          end
          default: ;
        endcase
      end

      if (fall_e && out_phase) begin
        if (bit_cnt == 3'd0) begin
          miso      <= load_byte[7];
          tx_sr     <= {load_byte[6:0], 1'b0};
          tx_active <= 1'b1;
          if (ph == PH_RD_DATA) ptr <= ptr + 1'b1;
        end else begin
          miso  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/spi_fram_slave.sv
module spi_fram_slave #(
  parameter int AW          = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  input  logic hold_n,
  output logic miso,
  output logic miso_oe
);
  logic          cs_s, mosi_s, wp_s, rise_e, fall_e, hold_on;
  logic          ram_we, st_we, armed, wel, wpen;
  logic [1:0]    bp;
  logic [AW-1:0] ptr;
  logic [7:0]    ram_wdata, ram_q;

  fram_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) i_pins (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .hold_n(hold_n), .cs_s(cs_s), .mosi_s(mosi_s),
    .wp_s(wp_s), .rise_e(rise_e), .fall_e(fall_e), .hold_on(hold_on)
  );

  fram_ctrl #(.AW(AW)) i_ctrl (
    .clk(clk), .rst(rst), .cs_s(cs_s), .mosi_s(mosi_s), .wp_s(wp_s),
    .rise_e(rise_e), .fall_e(fall_e), .hold_on(hold_on), .ram_q(ram_q),
    .ram_we(ram_we), .ptr(ptr), .ram_wdata(ram_wdata), .miso(miso),
    .miso_oe(miso_oe), .wel(wel), .wpen(wpen), .bp(bp), .st_we(st_we),
    .armed(armed)
  );

  fram_array #(.AW(AW), .DW(8)) i_array (
    .clk(clk), .we(ram_we), .addr(ptr), .wdata(ram_wdata), .q(ram_q)
  );

endmodule

// File: rtl/fram_spi_mem_chk.sv
module fram_spi_mem_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_s,
  input logic          hold_on,
  input logic          miso_oe,
  input logic          ram_we,
  input logic [AW-1:0] ptr,
  input logic          wel,
  input logic          wpen,
  input logic          wp_s,
  input logic [1:0]    bp,
  input logic          st_we,
  input logic          armed
);
  logic in_fence;
  always_comb begin
    unique case (bp)
      2'b00: in_fence = 1'b0;
      2'b01: in_fence = (ptr >= AW'(3 << (AW - 2)));
      2'b10: in_fence = (ptr >= AW'(1 << (AW - 1)));
      default: in_fence = 1'b1;
    endcase
  end

  p_store_needs_latch_r5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> wel);

  p_store_outside_fence_r9: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !in_fence);

  p_pointer_steps_r3: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> (ptr == $past(ptr) + AW'(1)));

  p_status_needs_latch_r8: assert property (@(posedge clk) disable iff (rst)
    st_we |-> wel);

  p_status_pin_lock_r10: assert property (@(posedge clk) disable iff (rst)
    st_we |-> !(wpen && !wp_s));

  p_latch_drops_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_s) && armed) |=> !wel);

  p_quiet_when_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> !miso_oe);

  p_quiet_in_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (hold_on && $past(hold_on)) |-> !miso_oe);

endmodule

bind spi_fram_slave fram_spi_mem_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .hold_on(hold_on), .miso_oe(miso_oe),
  .ram_we(ram_we), .ptr(ptr), .wel(wel), .wpen(wpen), .wp_s(wp_s),
  .bp(bp), .st_we(st_we), .armed(armed)
);

// File: tb/test_spi_fram_slave.sv
module test_spi_fram_slave;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic miso, miso_oe;

  always #2 clk = ~clk;

  spi_fram_slave #(.AW(AW)) i_spi_fram_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .hold_n(hold_n), .miso(miso), .miso_oe(miso_oe)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state.
  logic [7:0] mm [int];
  bit         m_wel = 0, m_wpen = 0;
  logic [1:0] m_bp = 2'b00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_prot(input int a);
    case (m_bp)
      2'b00: return 0;
      2'b01: return a >= (3 * DEPTH / 4);
      2'b10: return a >= (DEPTH / 2);
      default: return 1;
    endcase
  endfunction

  function automatic bit m_locked();
    return m_wpen && !wp_n;
  endfunction

  function automatic logic [7:0] m_status();
    return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  // R12: every clock with chip select idle the MISO enable stays low.
  int idle_cnt = 0;
  always @(negedge clk) begin
    if (rst || !cs_n) idle_cnt <= 0;
    else begin
      idle_cnt <= idle_cnt + 1;
      if (idle_cnt >= 4) check(miso_oe == 1'b0, "R12 idle oe", miso_oe, 0);
    end
  end

  task automatic do_hold();
    hold_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      mosi = ~mosi;
      sck = 1'b1; repeat (HALF) @(negedge clk);
      check(miso_oe == 1'b0, "R11 hold oe", miso_oe, 0);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      input int hold_at = -1, input int nbits = 8);
    rx = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      if (i == hold_at) do_hold();
      mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic op_simple(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xfer(op, r); cs_hi();
    if (op == 8'h06 && !m_locked()) m_wel = 1;
    if (op == 8'h04) m_wel = 0;
  endtask

  task automatic op_rdsr(input string req, input int reps = 1);
    logic [7:0] r;
    cs_lo(); xfer(8'h05, r);
    for (int k = 0; k < reps; k++) begin
      xfer(8'h00, r);
      check(r == m_status(), req, r, m_status());
    end
    cs_hi();
  endtask

  task automatic op_wrsr(input logic [7:0] v);
    logic [7:0] r;
    bit armed;
    armed = m_wel && !m_locked();
    cs_lo(); xfer(8'h01, r); xfer(v, r); cs_hi();
    if (armed) begin
      m_wpen = v[7]; m_bp = v[3:2]; m_wel = 0;
    end
  endtask

  task automatic op_write(input int addr16, input logic [7:0] d [$], input int hold_at = -1);
    logic [7:0] r;
    bit armed;
    int a;
    armed = m_wel;
    a = addr16 % DEPTH;
    cs_lo(); xfer(8'h02, r); xfer(addr16[15:8], r); xfer(addr16[7:0], r);
    foreach (d[k]) begin
      xfer(d[k], r, (k == 1) ? hold_at : -1);
      if (armed && !m_prot(a)) mm[a] = d[k];
      a = (a + 1) % DEPTH;
    end
    cs_hi();
    if (armed) m_wel = 0;
  endtask

  task automatic op_read(input int addr16, input int n, input string req, input int hold_at = -1);
    logic [7:0] r;
    int a;
    a = addr16 % DEPTH;
    cs_lo(); xfer(8'h03, r); xfer(addr16[15:8], r); xfer(addr16[7:0], r);
    for (int k = 0; k < n; k++) begin
      xfer(8'hFF, r, (k == 1) ? hold_at : -1);
      if (mm.exists(a)) check(r == mm[a], req, r, mm[a]);
      a = (a + 1) % DEPTH;
    end
    check(miso_oe == 1'b1, "R12 read oe", miso_oe, 1);
    cs_hi();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R12 reset state
    check(miso_oe == 1'b0, "R12 reset oe", miso_oe, 0);
    op_rdsr("R12 reset status");

    // R4 / R3 / R2 / R6 basic write and read
    op_simple(8'h06);
    op_rdsr("R4 wren status");
    op_write(16'h0010, '{8'h11, 8'h22, 8'h33, 8'h44});
    op_rdsr("R6 latch cleared after write");
    op_read(16'h0010, 4, "R2 read stream");

    // R5 write without latch is dropped
    op_write(16'h0010, '{8'hEE});
    op_read(16'h0010, 1, "R5 unarmed write");

    // R3 wrap across the array end, R2 wrap on read, high address bits ignored
    op_simple(8'h06);
    op_write(DEPTH - 2, '{8'hA1, 8'hA2, 8'hA3, 8'hA4});
    op_read(DEPTH - 1, 3, "R3 wrap");
    op_read(16'hF810, 2, "R2 high bits ignored");

    // R4 WRDI, R7 repeated status
    op_simple(8'h06); op_simple(8'h04);
    op_rdsr("R4 wrdi");
    op_simple(8'h06);
    op_rdsr("R7 repeat", 3);

    // R1 unknown opcode and trailing bytes change nothing
    cs_lo(); xfer(8'hAB, r); xfer(8'h02, r); xfer(8'h00, r); cs_hi();
    op_rdsr("R1 unknown op");

    // R9 quarter and half protection
    op_write(16'h03FF, '{8'h5A, 8'h5B});
    op_simple(8'h06);
    op_write(16'h05FF, '{8'h6A, 8'h6B});
    op_simple(8'h06);
    op_wrsr(8'h77);  // R8: bits 7,3,2 -> wpen 0, bp 01
    op_rdsr("R8 wrsr load");
    op_simple(8'h06);
    op_write(16'h05FF, '{8'h7A, 8'h7B});
    op_read(16'h05FF, 2, "R9 top quarter");
    op_simple(8'h06);
    op_wrsr(8'h08);
    op_simple(8'h06);
    op_write(16'h03FF, '{8'h8A, 8'h8B});
    op_read(16'h03FF, 2, "R9 top half");
    op_simple(8'h06);
    op_wrsr(8'h0C);
    op_simple(8'h06);
    op_write(16'h0010, '{8'h99});
    op_read(16'h0010, 1, "R9 whole array");

    // R10 pin lock
    op_simple(8'h06);
    op_wrsr(8'h80);
    op_rdsr("R8 wpen set");
    wp_n = 1'b0;
    op_simple(8'h06);
    op_rdsr("R10 wren locked");
    wp_n = 1'b1;
    op_simple(8'h06);
    wp_n = 1'b0;
    op_wrsr(8'h00);
    op_rdsr("R10 wrsr locked");
    wp_n = 1'b1;
    op_wrsr(8'h00);
    wp_n = 1'b0;
    op_simple(8'h06);
    op_rdsr("R10 pin inactive");
    wp_n = 1'b1;

    // R11 hold during write and read
    op_write(16'h0100, '{8'hC1, 8'hC2, 8'hC3}, 3);
    op_read(16'h0100, 3, "R11 hold", 4);

    // R3 partial byte discarded
    op_simple(8'h06);
    op_write(16'h0021, '{8'h55});
    op_simple(8'h06);
    cs_lo(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h20, r); xfer(8'h77, r);
    xfer(8'hF0, r, -1, 4); cs_hi();
    mm[32'h20] = 8'h77; m_wel = 0;
    op_read(16'h0020, 2, "R3 partial byte");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule